// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block is a real-time clock peripheral on a byte-wide register bus. It holds a free-running unsigned count of seconds that advances on a single-cycle tick input while counting is switched on. Software sets the time by first writing the three upper bytes into staging registers. It then writes the least significant byte, and that write moves the whole value into the counter in one clock. The live count can be read one byte at a time, least significant byte first. A carry out of the low byte can happen between two byte reads. Software detects this by reading the low byte again and comparing.

A second register of the same width holds the alarm time. When the alarm is enabled and the count equals the alarm time, a pending flag is set and the interrupt output goes high. The output stays high until software writes a one to the clear bit. Even if the alarm is disabled in the meantime, the output stays high. The pending flag is kept by a three-state machine: `AL_OFF` (alarm disabled, nothing pending), `AL_WATCH` (enabled, waiting for a match) and `AL_FIRED` (pending, interrupt high). The transitions are as follows. OFF→WATCH happens when the enable bit is set. WATCH→OFF happens when the enable bit is cleared. OFF or WATCH→FIRED happens when the alarm is enabled and the count matches. FIRED→FIRED happens when a clear arrives but the alarm is still enabled and still matching. FIRED→WATCH or FIRED→OFF happens when a clear arrives without a fresh match; the target depends on the enable bit.

With the default parameters, the register map is:

| Address | Register |
|---|---|
| 0x0 | control, bit 7 = run |
| 0x1 | alarm control, bit 1 = enable, bit 0 = clear on write and pending on read |
| 0x2–0x5 | time load bytes 0..3, write-only |
| 0x6–0x9 | live count bytes 0..3, read-only |
| 0xA–0xD | alarm bytes 0..3 |

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset, the count, the staged bytes, the alarm time, run, alarm enable and the pending flag are all zero. The interrupt output is low and every readable register returns 0x00.
- R2: While run (address 0x0, bit 7) is 1, each cycle with `tick` high adds one to the count, and the count wraps from 0xFFFFFFFF to 0. While run is 0, the count holds.
- R3: Writes to addresses 0x3, 0x4 and 0x5 only stage bytes 1, 2 and 3 and leave the count unchanged. A write to address 0x2 loads {staged byte 3, byte 2, byte 1, written byte} into the count at that clock edge. This load takes precedence over a tick in the same cycle.
- R4: Addresses 0x6 to 0x9 return bytes 0 to 3 of the live count, little-endian, in the same cycle as the address.
- R5: Addresses 0xA to 0xD are written and read back as alarm bytes 0 to 3, little-endian.
- R6: When the alarm enable (address 0x1, bit 1) is 1 and the count equals the alarm time at a clock edge, the interrupt output is high from that edge on. It stays high until cleared, even if the alarm enable is then cleared.
- R7: Writing address 0x1 with bit 0 set clears the pending interrupt. If the enabled alarm still matches in the same cycle, setting wins and the interrupt stays high.
- R8: While the alarm enable is 0, a match between count and alarm time does not raise the interrupt.
- R9: Reads of addresses 0x2 to 0x5, 0xE and 0xF return 0x00. Writes to addresses 0x6 to 0x9 change nothing.
- R10: Address 0x0 reads back run in bit 7, with all other bits 0. Address 0x1 reads back the enable in bit 1 and the pending flag in bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle seconds pulse |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| alarm_irq | output | 1 | Alarm interrupt level |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that at most one register write happens per cycle. They also assume the bus holds still outside the cycle that carries the write strobe. The bench drives every input on the falling edge. It raises `tick` or `bus_we` for exactly one cycle and never drives a tick during a multi-byte read of the count, so the torn-read case never appears in its expected values. The random part loads arbitrary 32-bit times, including times next to the wrap point, and issues a random number of ticks with run randomly on or off.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
    // Alarm pending state machine
    typedef enum logic [1:0] {
        AL_OFF   = 2'd0,
        AL_WATCH = 2'd1,
        AL_FIRED = 2'd2
    } alarm_state_e;

    // Fixed control bit positions
    localparam int RUN_BIT   = 7;
    localparam int AL_EN_BIT = 1;
    localparam int AL_CL_BIT = 0;
endpackage

// File: rtl/rtc_sec_regs.sv
module rtc_sec_regs #(
    parameter int DATA_W = 8,
    parameter int NBYTES = 4,
    parameter int ADDR_W = 4,
    localparam int CNT_W = DATA_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              pending,
    output logic              run,
    output logic              alarm_en,
    output logic              clr,
    output logic              load,
    output logic [CNT_W-1:0]  load_value,
    output logic [CNT_W-1:0]  alarm_value,
    output logic [DATA_W-1:0] rdata
);
    import rtc_sec_pkg::*;

    localparam int A_CTRL  = 0;
    localparam int A_ALCTL = 1;
    localparam int A_WR    = 2;
    localparam int A_RD    = A_WR + NBYTES;
    localparam int A_AL    = A_RD + NBYTES;

    logic [CNT_W-1:0] stage_q;

    assign load = we && (addr == ADDR_W'(A_WR));
    assign clr  = we && (addr == ADDR_W'(A_ALCTL)) && wdata[AL_CL_BIT];

    // Control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run      <= 1'b0;
            alarm_en <= 1'b0;
        end else if (we) begin
            if (addr == ADDR_W'(A_CTRL))  run      <= wdata[RUN_BIT];
            if (addr == ADDR_W'(A_ALCTL)) alarm_en <= wdata[AL_EN_BIT];
        end
    end

    // Byte 0 of the staging register is never stored; it comes from the bus
    assign stage_q[DATA_W-1:0] = '0;

    for (genvar i = 1; i < NBYTES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stage_q[i*DATA_W +: DATA_W] <= '0;
            else if (we && addr == ADDR_W'(A_WR + i))
                stage_q[i*DATA_W +: DATA_W] <= wdata;
        end
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_alarm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alarm_value[i*DATA_W +: DATA_W] <= '0;
            else if (we && addr == ADDR_W'(A_AL + i))
                alarm_value[i*DATA_W +: DATA_W] <= wdata;
        end
    end

    always_comb begin
        load_value = stage_q;
        load_value[DATA_W-1:0] = wdata;
    end

    // Read multiplexer: unmapped and write-only addresses return zero
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL))
            rdata[RUN_BIT] = run;
        if (addr == ADDR_W'(A_ALCTL)) begin
            rdata[AL_EN_BIT] = alarm_en;
            rdata[AL_CL_BIT] = pending;
        end
        for (int i = 0; i < NBYTES; i++) begin
            if (addr == ADDR_W'(A_RD + i))
                rdata = count[i*DATA_W +: DATA_W];
            if (addr == ADDR_W'(A_AL + i))
                rdata = alarm_value[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_value;
        else if (run && tick)
            count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/rtc_sec_alarm_fsm.sv
module rtc_sec_alarm_fsm #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] alarm_value,
    output logic             pending
);
    import rtc_sec_pkg::*;

    alarm_state_e state_q, state_d;
    logic hit;

    assign hit = en && (count == alarm_value);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AL_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AL_OFF: begin
                if (hit)     state_d = AL_FIRED;
                else if (en) state_d = AL_WATCH;
            end
            AL_WATCH: begin
                if (hit)     state_d = AL_FIRED;
                else if (!en) state_d = AL_OFF;
            end
            AL_FIRED: begin
                if (clr && !hit) state_d = en ? AL_WATCH : AL_OFF;
            end
            default: state_d = AL_OFF;
        endcase
    end

    always_comb begin
        pending = (state_q == AL_FIRED);
    end
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm #(
    parameter int DATA_W = 8,
    parameter int NBYTES = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              alarm_irq
);
    localparam int CNT_W = DATA_W * NBYTES;

    logic             run, alarm_en, clr, load, pending;
    logic [CNT_W-1:0] load_value, alarm_value, count;

    rtc_sec_regs #(.DATA_W(DATA_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .count(count), .pending(pending), .run(run), .alarm_en(alarm_en),
        .clr(clr), .load(load), .load_value(load_value),
        .alarm_value(alarm_value), .rdata(bus_rdata)
    );

    rtc_sec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .load(load),
        .load_value(load_value), .count(count)
    );

    rtc_sec_alarm_fsm #(.CNT_W(CNT_W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .en(alarm_en), .clr(clr), .count(count),
        .alarm_value(alarm_value), .pending(pending)
    );

    assign alarm_irq = pending;
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             run,
    input logic             alarm_en,
    input logic             clr,
    input logic             load,
    input logic [CNT_W-1:0] load_value,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] alarm_value,
    input logic             alarm_irq
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(run && tick)) |=> $stable(count));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && run && tick) |=> (count == $past(count) + CNT_W'(1)));

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_value)));

    p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_en && count == alarm_value) |=> alarm_irq);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq && !clr) |=> alarm_irq);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq && clr && !(alarm_en && count == alarm_value)) |=> !alarm_irq);

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_irq && !alarm_en) |=> !alarm_irq);
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .alarm_en(alarm_en),
    .clr(clr), .load(load), .load_value(load_value), .count(count),
    .alarm_value(alarm_value), .alarm_irq(alarm_irq)
);

// File: tb/test_rtc_sec_alarm.sv
module test_rtc_sec_alarm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       alarm_irq;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    rtc_sec_alarm i_rtc_sec_alarm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alarm_irq(alarm_irq)
    );

    function automatic logic [31:0] after_ticks(logic [31:0] v, bit on, int n);
        return on ? v + 32'(n) : v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic pulse;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd32(logic [3:0] base, output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(base + 4'(i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic set_time(logic [31:0] v);
        wr(4'h3, v[15:8]); wr(4'h4, v[23:16]); wr(4'h5, v[31:24]);
        wr(4'h2, v[7:0]);
    endtask

    task automatic set_alarm(logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(4'hA + 4'(i), v[i*8 +: 8]);
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v, got, exp;
        logic [7:0]  b;
        void'($urandom(32'd20240601));
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", 32'(alarm_irq), 0);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), b);
            check("R1 reg", 32'(b), 0);
        end

        // R2 hold while stopped
        set_time(32'h0000_0010);
        pulse(); pulse();
        rd32(4'h6, got); check("R2 hold", got, 32'h10);
        wr(4'h0, 8'h80);
        rd(4'h0, b); check("R10 ctrl", 32'(b), 32'h80);
        pulse(); pulse(); pulse();
        rd32(4'h6, got); check("R2 count", got, 32'h13);

        // R2 wrap
        set_time(32'hFFFF_FFFF);
        pulse();
        rd32(4'h6, got); check("R2 wrap", got, 0);

        // R3 staging leaves count, R4 byte order
        set_time(32'h1122_3344);
        wr(4'h3, 8'hAA); wr(4'h4, 8'hBB); wr(4'h5, 8'hCC);
        rd32(4'h6, got); check("R3 staged", got, 32'h1122_3344);
        rd(4'h6, b); check("R4 byte0", 32'(b), 32'h44);
        rd(4'h9, b); check("R4 byte3", 32'(b), 32'h11);

        // R3 load wins over tick
        @(negedge clk);
        bus_addr = 4'h2; bus_wdata = 8'hDD; bus_we = 1'b1; tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick = 1'b0;
        rd32(4'h6, got); check("R3 load over tick", got, 32'hCCBB_AADD);

        // R9 read-only writes ignored, unmapped reads zero
        wr(4'h6, 8'h00); wr(4'h9, 8'h00);
        rd32(4'h6, got); check("R9 ro write", got, 32'hCCBB_AADD);
        rd(4'hE, b); check("R9 unmapped", 32'(b), 0);
        rd(4'h4, b); check("R9 write-only", 32'(b), 0);

        // R5 alarm read back
        set_alarm(32'hDEAD_BEEF);
        rd32(4'hA, got); check("R5 alarm", got, 32'hDEAD_BEEF);

        // R8 match without enable
        wr(4'h0, 8'h00);
        set_time(32'h0000_0100);
        set_alarm(32'h0000_0100);
        idle(3);
        check("R8 no irq", 32'(alarm_irq), 0);

        // R6 fire on a tick to the alarm time
        set_time(32'h0000_00FF);
        wr(4'h0, 8'h80);
        wr(4'h1, 8'h02);
        check("R6 before", 32'(alarm_irq), 0);
        pulse();
        idle(1);
        check("R6 fired", 32'(alarm_irq), 1);
        rd(4'h1, b); check("R10 alctl", 32'(b), 32'h03);

        // R7 set wins over clear while matching
        wr(4'h0, 8'h00);
        wr(4'h1, 8'h03);
        idle(1);
        check("R7 set wins", 32'(alarm_irq), 1);
        // R6 stays high after disable
        wr(4'h1, 8'h00);
        idle(2);
        check("R6 sticky", 32'(alarm_irq), 1);
        // R7 clear
        wr(4'h1, 8'h01);
        idle(1);
        check("R7 cleared", 32'(alarm_irq), 0);
        rd(4'h1, b); check("R7 alctl", 32'(b), 0);

        // Random loads and ticks (R2, R3, R4)
        for (int it = 0; it < 40; it++) begin
            bit on;
            int n;
            v  = $urandom();
            if (it % 8 == 0) v = 32'hFFFF_FFFF - 32'($urandom_range(0, 3));
            on = 1'($urandom_range(0, 1));
            n  = $urandom_range(0, 5);
            wr(4'h0, on ? 8'h80 : 8'h00);
            set_time(v);
            rd32(4'h6, got); check("R3 random load", got, v);
            for (int k = 0; k < n; k++) pulse();
            exp = after_ticks(v, on, n);
            rd32(4'h6, got); check("R2 random ticks", got, exp);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule